// File: doc/BRIEF.md
# Mirrored Parity-Checked Bus Port

This block is the board-side end of a system bus that exists as two independent copies, called A and B. Each copy carries its own valid, control, address and data lines, plus one parity bit for every byte lane. The block drives both copies with the same word in the same cycle. When it receives, it decides which copy to trust. Two system-wide enable inputs tell every board to stop listening to a copy that has been judged suspect.

The receive path looks at whichever copies are enabled and checks the parity of each one. It compares the two copies when both can be trusted. It then returns a single word with a trust bit, and raises one-cycle flags that name the copy that failed parity or report that the copies disagree. Transmit and receive each have one register stage. Everything resets to zero, so that two lockstepped boards never hold undefined state.

Top module: `dualbus_port`

## Requirements
- R1: Parity is even and taken per byte lane. The protected word is {ctrl, addr, data}, with data in the least significant bits. Lane g covers word bits [8g+7:8g], and the top lane is padded with zeros. Parity bit g is the XOR of its lane, so a lane together with its parity bit always holds an even number of ones.
- R2: Copy A and copy B carry identical valid, ctrl, addr, data and parity values on every cycle.
- R3: A word offered with tx_req appears on both copies one clock later, with its valid bit set. While tx_req is low, every transmit line of both copies is driven to zero.
- R4: rx_vld rises for exactly one cycle, one clock after an edge at which at least one enabled copy had its valid bit high. Otherwise rx_vld is low and every receive output is zero.
- R5: A copy whose enable is low is ignored. Its valid, word and parity have no effect, and its parity-error flag never rises.
- R6: Both copies enabled, both valid, both parities correct and equal words: rx_ok is 1, the word is delivered, and no flag rises.
- R7: Both copies enabled, both valid, both parities correct but words differ: rx_cmp_err is 1, rx_ok is 0 and the word of copy A is delivered.
- R8: Both copies enabled and valid, with exactly one failing parity: the word of the other copy is delivered with rx_ok 1, and the failing copy's flag is set.
- R9: Both copies enabled and valid, with both failing parity: both flags are set, rx_ok is 0 and the word of copy A is delivered.
- R10: Both copies enabled but only one valid: rx_cmp_err is 1, rx_ok is 0, the word of the valid copy is delivered, and that copy's parity flag reflects its check.
- R11: Only one copy enabled and valid: its word is delivered, and rx_ok is the inverse of its parity flag.
- R12: rx_ok, rx_perr_a, rx_perr_b and rx_cmp_err are high only in a cycle where rx_vld is high.
- R13: During reset, and for the two clocks it takes to release it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_a | input | 1 | System enable for copy A |
| bus_en_b | input | 1 | System enable for copy B |
| tx_req | input | 1 | Send a word this cycle |
| tx_ctrl | input | CTRL_W | Control field to send |
| tx_addr | input | ADDR_W | Address to send |
| tx_data | input | DATA_W | Data to send |
| a_out_vld | output | 1 | Copy A transmit valid |
| a_out_ctrl | output | CTRL_W | Copy A transmit control |
| a_out_addr | output | ADDR_W | Copy A transmit address |
| a_out_data | output | DATA_W | Copy A transmit data |
| a_out_par | output | LANES | Copy A transmit lane parity |
| b_out_vld | output | 1 | Copy B transmit valid |
| b_out_ctrl | output | CTRL_W | Copy B transmit control |
| b_out_addr | output | ADDR_W | Copy B transmit address |
| b_out_data | output | DATA_W | Copy B transmit data |
| b_out_par | output | LANES | Copy B transmit lane parity |
| a_in_vld | input | 1 | Copy A receive valid |
| a_in_ctrl | input | CTRL_W | Copy A receive control |
| a_in_addr | input | ADDR_W | Copy A receive address |
| a_in_data | input | DATA_W | Copy A receive data |
| a_in_par | input | LANES | Copy A receive lane parity |
| b_in_vld | input | 1 | Copy B receive valid |
| b_in_ctrl | input | CTRL_W | Copy B receive control |
| b_in_addr | input | ADDR_W | Copy B receive address |
| b_in_data | input | DATA_W | Copy B receive data |
| b_in_par | input | LANES | Copy B receive lane parity |
| rx_vld | output | 1 | Received-word strobe |
| rx_ctrl | output | CTRL_W | Selected control |
| rx_addr | output | ADDR_W | Selected address |
| rx_data | output | DATA_W | Selected data |
| rx_ok | output | 1 | Selected word is trustworthy |
| rx_perr_a | output | 1 | Copy A parity failure |
| rx_perr_b | output | 1 | Copy B parity failure |
| rx_cmp_err | output | 1 | Copies disagree |

## Verification
The assertions check, on every cycle, the following: the two transmit copies stay identical, the transmit parity is correct, a requested word reaches both copies one clock later, and the flags never appear without the strobe. They also check that a disabled copy never raises its flag and that a compare error always withholds trust. With a single copy enabled, they check that its word and parity verdict pass straight through. The voting rules for two enabled copies can only be shown by the bench's sweep. That sweep runs every combination of the enables, the valid bits, parity corruption in each lane and differing words. It shows which copy is chosen and which flags rise in each case.

// File: rtl/dualbus_pkg.sv
package dualbus_pkg;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } src_e;

  typedef struct packed {
    logic fire;
    logic good;
    logic perr_a;
    logic perr_b;
    logic cmp_err;
    src_e src;
  } verdict_t;

  function automatic int unsigned lane_count(input int unsigned w);
    return (w + 7) / 8;
  endfunction

endpackage

// File: rtl/dualbus_parity.sv
module dualbus_parity #(
  parameter int W     = 16,
  parameter int LANES = 2
) (
  input  logic [W-1:0]     word,
  output logic [LANES-1:0] par
);
  localparam int PADW = LANES * 8;

  logic [PADW-1:0] padded;
  assign padded = PADW'(word);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ^padded[8*g +: 8];
  end
endmodule

// File: rtl/dualbus_tx.sv
module dualbus_tx #(
  parameter int W     = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [W-1:0]     word,
  output logic             out_vld,
  output logic [W-1:0]     out_word,
  output logic [LANES-1:0] out_par
);
  logic             vld_d;
  logic [W-1:0]     word_d;
  logic [LANES-1:0] par_d;

  always_comb begin
    vld_d  = req;
    word_d = req ? word : '0;
  end

  dualbus_parity #(.W(W), .LANES(LANES)) u_par (
    .word (word_d),
    .par  (par_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= '0;
      out_par  <= '0;
    end else begin
      out_vld  <= vld_d;
      out_word <= word_d;
      out_par  <= par_d;
    end
  end
endmodule

// File: rtl/dualbus_rx_vote.sv
module dualbus_rx_vote
  import dualbus_pkg::*;
#(
  parameter int W     = 16,
  parameter int LANES = 2
) (
  input  logic             en_a,
  input  logic             en_b,
  input  logic             vld_a,
  input  logic             vld_b,
  input  logic [W-1:0]     word_a,
  input  logic [W-1:0]     word_b,
  input  logic [LANES-1:0] par_a,
  input  logic [LANES-1:0] par_b,
  output verdict_t         vd,
  output logic [W-1:0]     pick
);
  logic [LANES-1:0] calc_a, calc_b;
  logic use_a, use_b, bad_a, bad_b;

  dualbus_parity #(.W(W), .LANES(LANES)) u_chk_a (.word(word_a), .par(calc_a));
  dualbus_parity #(.W(W), .LANES(LANES)) u_chk_b (.word(word_b), .par(calc_b));

  assign use_a = en_a & vld_a;
  assign use_b = en_b & vld_b;
  assign bad_a = use_a & (calc_a != par_a);
  assign bad_b = use_b & (calc_b != par_b);

  always_comb begin
    vd         = '0;
    vd.src     = SEL_A;
    vd.fire    = use_a | use_b;
    if (vd.fire) begin
      vd.perr_a = bad_a;
      vd.perr_b = bad_b;
      if (en_a && en_b) begin
        if (vld_a != vld_b) begin
          vd.cmp_err = 1'b1;
          vd.src     = use_a ? SEL_A : SEL_B;
        end else if (!bad_a && !bad_b) begin
          if (word_a == word_b) vd.good    = 1'b1;
          else                  vd.cmp_err = 1'b1;
        end else if (bad_a && !bad_b) begin
          vd.src  = SEL_B;
          vd.good = 1'b1;
        end else if (!bad_a && bad_b) begin
          vd.good = 1'b1;
        end
      end else begin
        vd.src  = use_a ? SEL_A : SEL_B;
        vd.good = use_a ? !bad_a : !bad_b;
      end
    end
  end

  assign pick = (vd.src == SEL_B) ? word_b : word_a;
endmodule

// File: rtl/dualbus_port.sv
module dualbus_port
  import dualbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CTRL_W = 4,
  localparam int W     = DATA_W + ADDR_W + CTRL_W,
  localparam int LANES = dualbus_pkg::lane_count(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_a,
  input  logic              bus_en_b,
  input  logic              tx_req,
  input  logic [CTRL_W-1:0] tx_ctrl,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              a_out_vld,
  output logic [CTRL_W-1:0] a_out_ctrl,
  output logic [ADDR_W-1:0] a_out_addr,
  output logic [DATA_W-1:0] a_out_data,
  output logic [LANES-1:0]  a_out_par,
  output logic              b_out_vld,
  output logic [CTRL_W-1:0] b_out_ctrl,
  output logic [ADDR_W-1:0] b_out_addr,
  output logic [DATA_W-1:0] b_out_data,
  output logic [LANES-1:0]  b_out_par,
  input  logic              a_in_vld,
  input  logic [CTRL_W-1:0] a_in_ctrl,
  input  logic [ADDR_W-1:0] a_in_addr,
  input  logic [DATA_W-1:0] a_in_data,
  input  logic [LANES-1:0]  a_in_par,
  input  logic              b_in_vld,
  input  logic [CTRL_W-1:0] b_in_ctrl,
  input  logic [ADDR_W-1:0] b_in_addr,
  input  logic [DATA_W-1:0] b_in_data,
  input  logic [LANES-1:0]  b_in_par,
  output logic              rx_vld,
  output logic [CTRL_W-1:0] rx_ctrl,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ok,
  output logic              rx_perr_a,
  output logic              rx_perr_b,
  output logic              rx_cmp_err
);
  localparam int COPIES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // transmit: one mirrored stage per copy
  logic [W-1:0]     tx_word;
  logic             cp_vld  [COPIES];
  logic [W-1:0]     cp_word [COPIES];
  logic [LANES-1:0] cp_par  [COPIES];

  assign tx_word = {tx_ctrl, tx_addr, tx_data};

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    dualbus_tx #(.W(W), .LANES(LANES)) u_tx (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req      (tx_req),
      .word     (tx_word),
      .out_vld  (cp_vld[c]),
      .out_word (cp_word[c]),
      .out_par  (cp_par[c])
    );
  end

  assign a_out_vld = cp_vld[0];
  assign a_out_par = cp_par[0];
  assign {a_out_ctrl, a_out_addr, a_out_data} = cp_word[0];
  assign b_out_vld = cp_vld[1];
  assign b_out_par = cp_par[1];
  assign {b_out_ctrl, b_out_addr, b_out_data} = cp_word[1];

  // receive: vote, then register
  verdict_t     vd;
  logic [W-1:0] pick;

  dualbus_rx_vote #(.W(W), .LANES(LANES)) u_vote (
    .en_a   (bus_en_a),
    .en_b   (bus_en_b),
    .vld_a  (a_in_vld),
    .vld_b  (b_in_vld),
    .word_a ({a_in_ctrl, a_in_addr, a_in_data}),
    .word_b ({b_in_ctrl, b_in_addr, b_in_data}),
    .par_a  (a_in_par),
    .par_b  (b_in_par),
    .vd     (vd),
    .pick   (pick)
  );

  logic         rx_vld_d, rx_ok_d, perr_a_d, perr_b_d, cmp_d;
  logic [W-1:0] rx_word_d, rx_word_q;

  always_comb begin
    rx_vld_d  = vd.fire;
    rx_word_d = vd.fire ? pick : '0;
    rx_ok_d   = vd.fire & vd.good;
    perr_a_d  = vd.fire & vd.perr_a;
    perr_b_d  = vd.fire & vd.perr_b;
    cmp_d     = vd.fire & vd.cmp_err;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_vld     <= 1'b0;
      rx_word_q  <= '0;
      rx_ok      <= 1'b0;
      rx_perr_a  <= 1'b0;
      rx_perr_b  <= 1'b0;
      rx_cmp_err <= 1'b0;
    end else begin
      rx_vld     <= rx_vld_d;
      rx_word_q  <= rx_word_d;
      rx_ok      <= rx_ok_d;
      rx_perr_a  <= perr_a_d;
      rx_perr_b  <= perr_b_d;
      rx_cmp_err <= cmp_d;
    end
  end

  assign {rx_ctrl, rx_addr, rx_data} = rx_word_q;
endmodule

// File: rtl/dualbus_port_chk.sv
module dualbus_port_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CTRL_W = 4,
  localparam int W     = DATA_W + ADDR_W + CTRL_W,
  localparam int LANES = dualbus_pkg::lane_count(W)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_en_a,
  input logic              bus_en_b,
  input logic              tx_req,
  input logic [CTRL_W-1:0] tx_ctrl,
  input logic [ADDR_W-1:0] tx_addr,
  input logic [DATA_W-1:0] tx_data,
  input logic              a_out_vld,
  input logic [CTRL_W-1:0] a_out_ctrl,
  input logic [ADDR_W-1:0] a_out_addr,
  input logic [DATA_W-1:0] a_out_data,
  input logic [LANES-1:0]  a_out_par,
  input logic              b_out_vld,
  input logic [CTRL_W-1:0] b_out_ctrl,
  input logic [ADDR_W-1:0] b_out_addr,
  input logic [DATA_W-1:0] b_out_data,
  input logic [LANES-1:0]  b_out_par,
  input logic              a_in_vld,
  input logic [CTRL_W-1:0] a_in_ctrl,
  input logic [ADDR_W-1:0] a_in_addr,
  input logic [DATA_W-1:0] a_in_data,
  input logic [LANES-1:0]  a_in_par,
  input logic              b_in_vld,
  input logic [CTRL_W-1:0] b_in_ctrl,
  input logic [ADDR_W-1:0] b_in_addr,
  input logic [DATA_W-1:0] b_in_data,
  input logic [LANES-1:0]  b_in_par,
  input logic              rx_vld,
  input logic [CTRL_W-1:0] rx_ctrl,
  input logic [ADDR_W-1:0] rx_addr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ok,
  input logic              rx_perr_a,
  input logic              rx_perr_b,
  input logic              rx_cmp_err
);
  function automatic logic [LANES-1:0] lane_par(input logic [W-1:0] w);
    logic [LANES*8-1:0] p;
    logic [LANES-1:0]   r;
    p = (LANES*8)'(w);
    for (int g = 0; g < LANES; g++) r[g] = ^p[8*g +: 8];
    return r;
  endfunction

  logic only_a, only_b, par_ok_a, par_ok_b;
  assign only_a   = bus_en_a && !bus_en_b && a_in_vld;
  assign only_b   = bus_en_b && !bus_en_a && b_in_vld;
  assign par_ok_a = (a_in_par == lane_par({a_in_ctrl, a_in_addr, a_in_data}));
  assign par_ok_b = (b_in_par == lane_par({b_in_ctrl, b_in_addr, b_in_data}));

  AST_TX_MIRROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    {a_out_vld, a_out_ctrl, a_out_addr, a_out_data, a_out_par} ==
    {b_out_vld, b_out_ctrl, b_out_addr, b_out_data, b_out_par}); // R2

  AST_TX_PARITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    a_out_par == lane_par({a_out_ctrl, a_out_addr, a_out_data})); // R1

  AST_TX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_req |=> (a_out_vld && {a_out_ctrl, a_out_addr, a_out_data} ==
                $past({tx_ctrl, tx_addr, tx_data}))); // R3

  AST_FLAGS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_ok || rx_perr_a || rx_perr_b || rx_cmp_err) |-> rx_vld); // R12

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_vld |-> ({rx_ctrl, rx_addr, rx_data} == '0)); // R4

  AST_NO_SOURCE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(bus_en_a && a_in_vld) && !(bus_en_b && b_in_vld)) |=> !rx_vld); // R4

  AST_OFF_A_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_en_a |=> !rx_perr_a); // R5

  AST_OFF_B_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_en_b |=> !rx_perr_b); // R5

  AST_CMP_NOT_OK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_cmp_err |-> !rx_ok); // R7

  AST_ONE_BAD_TRUSTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_en_a && bus_en_b) |=> (!(rx_perr_a ^ rx_perr_b) || rx_cmp_err || rx_ok)); // R8

  AST_ONLY_A_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    only_a |=> ({rx_ctrl, rx_addr, rx_data} == $past({a_in_ctrl, a_in_addr, a_in_data})
                && rx_ok == $past(par_ok_a))); // R11

  AST_ONLY_B_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    only_b |=> ({rx_ctrl, rx_addr, rx_data} == $past({b_in_ctrl, b_in_addr, b_in_data})
                && rx_ok == $past(par_ok_b))); // R11
endmodule

bind dualbus_port dualbus_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/sim_dualbus_port.sv
module sim_dualbus_port;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int LN = 2;

  logic clk, rst_n, bus_en_a, bus_en_b, tx_req;
  logic [CW-1:0] tx_ctrl;
  logic [AW-1:0] tx_addr;
  logic [DW-1:0] tx_data;
  logic a_out_vld, b_out_vld;
  logic [CW-1:0] a_out_ctrl, b_out_ctrl;
  logic [AW-1:0] a_out_addr, b_out_addr;
  logic [DW-1:0] a_out_data, b_out_data;
  logic [LN-1:0] a_out_par, b_out_par;
  logic a_in_vld, b_in_vld;
  logic [CW-1:0] a_in_ctrl, b_in_ctrl;
  logic [AW-1:0] a_in_addr, b_in_addr;
  logic [DW-1:0] a_in_data, b_in_data;
  logic [LN-1:0] a_in_par, b_in_par;
  logic rx_vld, rx_ok, rx_perr_a, rx_perr_b, rx_cmp_err;
  logic [CW-1:0] rx_ctrl;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_data;

  int n_run, n_fail;
  bit done;

  dualbus_port #(.DATA_W(DW), .ADDR_W(AW), .CTRL_W(CW)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] par16(input logic [15:0] w);
    return {^w[15:8], ^w[7:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rx_vec();
    return 64'({rx_vld, rx_ok, rx_perr_a, rx_perr_b, rx_cmp_err, rx_ctrl, rx_addr, rx_data});
  endfunction

  function automatic logic [63:0] out_vec_a();
    return 64'({a_out_vld, a_out_par, a_out_ctrl, a_out_addr, a_out_data});
  endfunction

  function automatic logic [63:0] out_vec_b();
    return 64'({b_out_vld, b_out_par, b_out_ctrl, b_out_addr, b_out_data});
  endfunction

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_en_a = 1'b1; bus_en_b = 1'b1; tx_req = 1'b1;
    tx_ctrl = '1; tx_addr = '1; tx_data = '1;
    a_in_vld = 1'b1; b_in_vld = 1'b1;
    {a_in_ctrl, a_in_addr, a_in_data} = 16'h1234;
    {b_in_ctrl, b_in_addr, b_in_data} = 16'h1234;
    a_in_par = 2'b00; b_in_par = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R13 rx in reset", rx_vec(), 64'd0);
    check("R13 tx in reset", out_vec_a() | out_vec_b(), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tx_req = 1'b0; a_in_vld = 1'b0; b_in_vld = 1'b0;
    repeat (3) @(posedge clk);

    // transmit sweep
    for (int i = 0; i < 48; i++) begin
      logic [15:0] w;
      logic        rq;
      w  = 16'((i * 7919) ^ 16'h3c5a);
      rq = (i % 3) != 0;
      @(negedge clk);
      tx_req = rq;
      {tx_ctrl, tx_addr, tx_data} = w;
      @(posedge clk);
      #1;
      if (rq) begin
        check("R3 tx word", out_vec_a(), 64'({1'b1, par16(w), w}));
        check("R1 tx parity", 64'(a_out_par), 64'(par16(w)));
      end else begin
        check("R3 tx idle zero", out_vec_a(), 64'd0);
      end
      check("R2 mirror", out_vec_b(), out_vec_a());
    end
    @(negedge clk);
    tx_req = 1'b0;

    // receive sweep over enables, valids, lane corruption and word difference
    for (int m = 0; m < 256; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic ea, eb, va, vb, ua, ub, ba, bb;
        logic [1:0] fa, fb;
        logic [15:0] wa, wb, ew;
        logic ev, eok, epa, epb, ecmp;
        string tag;
        ea = m[0]; eb = m[1]; va = m[2]; vb = m[3];
        fa = 2'(m >> 4); fb = 2'(m >> 6);
        wa = 16'((m * 2654) ^ 16'ha55a ^ d);
        wb = (d != 0) ? (wa ^ 16'h0810) : wa;
        ua = ea & va; ub = eb & vb;
        ba = ua && (fa != 2'b00);
        bb = ub && (fb != 2'b00);
        ev = 0; eok = 0; epa = 0; epb = 0; ecmp = 0; ew = '0;
        if (!(ua || ub)) begin
          tag = ((va && !ea) || (vb && !eb)) ? "R5 R12" : "R4 R12";
        end else if (ea && eb) begin
          ev = 1; epa = ba; epb = bb;
          if (va != vb) begin
            ecmp = 1; ew = ua ? wa : wb; tag = "R10";
          end else if (!ba && !bb) begin
            ew = wa;
            if (wa == wb) begin eok = 1; tag = "R6"; end
            else begin ecmp = 1; tag = "R7"; end
          end else if (ba && bb) begin
            ew = wa; tag = "R9";
          end else begin
            ew = ba ? wb : wa; eok = 1; tag = "R8";
          end
        end else begin
          ev = 1; ew = ua ? wa : wb;
          if (ua) epa = ba; else epb = bb;
          eok = ua ? !ba : !bb;
          tag = (va && vb) ? "R5 R11" : "R11";
        end
        @(negedge clk);
        bus_en_a = ea; bus_en_b = eb; a_in_vld = va; b_in_vld = vb;
        {a_in_ctrl, a_in_addr, a_in_data} = wa;
        {b_in_ctrl, b_in_addr, b_in_data} = wb;
        a_in_par = par16(wa) ^ fa;
        b_in_par = par16(wb) ^ fb;
        @(posedge clk);
        #1;
        check(tag, rx_vec(), 64'({ev, eok, epa, epb, ecmp, ew}));
      end
    end

    // strobe lasts one cycle: idle the inputs and observe a low strobe
    @(negedge clk);
    a_in_vld = 1'b0; b_in_vld = 1'b0;
    @(posedge clk);
    #1;
    check("R4 single-cycle strobe", rx_vec(), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule